// File: doc/BRIEF.md
# Multi-Width Integer Add/Subtract Unit

This datapath unit performs the additive arithmetic of a processor core on byte, word and longword operands. It covers plain add and subtract, add and subtract chained through the incoming carry, register increment and decrement by small steps, longword address stepping by 1, 2 or 4, and a flag-driven packed-BCD correction of a byte result after an add or a subtract. The core's decoder supplies an operation code, a size code, the destination and source operands, a step code and the current flags. The unit returns the new destination value and the new flags one clock later.

The destination's bits above the selected width pass through unchanged. This lets the unit write its result straight back over a 32-bit register. Any combination of operation, size, step and immediate marker that is not allowed is reported on `illegal_o`. In that case the destination and the flags come back untouched.

Top module: `addsub_unit`

## Requirements
- R1: Codes ADD (op 0) and SUB (op 1) compute dst+src and dst-src at size 0 (8 bit), 1 (16 bit) or 2 (32 bit). Destination bits above the width are kept. Flags are packed {N,Z,V,C,H} in bits 4..0. N is the result MSB and Z is set for a zero result. V is signed overflow. C is the carry-out on an add and the borrow on a subtract. H is the carry or borrow out of bit 3, 11 or 27 for byte, word or longword.
- R2: ADDC (op 2) and SUBC (op 3) add or subtract the incoming C as well. Z is cleared for a nonzero result and keeps its incoming value for a zero result.
- R3: INC (op 4) and DEC (op 5) step dst by 1 (step code 0) or 2 (step code 1). N, Z and V are updated. C and H keep their incoming values.
- R4: INC or DEC is illegal for a byte with step code 1, and for step codes 2 or 3 at any size.
- R5: ADDA (op 6) and SUBA (op 7) step a longword by 1, 2 or 4 (step codes 0, 1, 2) and leave all five flags unchanged.
- R6: ADDA or SUBA is illegal for a size other than longword, and for step code 3.
- R7: DADJ_ADD (op 8) adds 0x06 when H=1 or the low digit is above 9. It adds 0x60 when C=1 or the byte is above 0x99, and that condition becomes the new C. DADJ_SUB (op 9) subtracts 0x06 when H=1 and 0x60 when C=1, and keeps C. Both ops update N and Z and keep V and H.
- R8: DADJ_ADD and DADJ_SUB are illegal at any size other than byte.
- R9: SUB at byte size with the immediate marker set is illegal. The same subtract at word size is legal.
- R10: An illegal request raises `illegal_o` and returns dst and the incoming flags unchanged. Size code 3 and op codes 10 to 15 are always illegal.
- R11: A request is taken on a clock edge with `valid_i` high, and its results appear one cycle later with `valid_o` high. Without `valid_i` the outputs hold their values. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| imm_i | input | 1 | Source is an immediate |
| step_i | input | 2 | Constant step code for INC/DEC/ADDA/SUBA |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| flags_i | input | 5 | Incoming flags {N,Z,V,C,H} |
| valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Request was rejected |
| res_o | output | 32 | Result value |
| flags_o | output | 5 | Outgoing flags {N,Z,V,C,H} |

## Verification
Errors in lane selection or width masking show up in the very next result. They appear as corrupted upper destination bits or as C, V or H taken from the wrong bit position. The vectors therefore put distinct patterns in the upper bytes and push each width across its sign and carry boundaries. An error in the flag-hold paths only shows when the incoming flags differ from what the arithmetic would produce, so the vectors that test hold behaviour use deliberately mismatched incoming flags. Because the unit has a single output register, any fault appears in the result that follows its request, and no later result depends on it.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned NLANE   = 3;
  localparam int unsigned FLAG_W  = 5;
  localparam int unsigned BCD_W   = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDC  = 4'd2,
    OP_SUBC  = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_ADDA  = 4'd6,
    OP_SUBA  = 4'd7,
    OP_DADJA = 4'd8,
    OP_DADJS = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } size_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic h;
  } flags_t;
endpackage

// File: rtl/addsub_legal.sv
module addsub_legal
  import addsub_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [1:0] size_i,
  input  logic       imm_i,
  input  logic [1:0] step_i,
  output logic       illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    if (size_i == SZ_X) illegal_o = 1'b1;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBC: ;
      OP_SUB:  if (size_i == SZ_B && imm_i) illegal_o = 1'b1;
      OP_INC, OP_DEC: begin
        if (step_i[1]) illegal_o = 1'b1;
        if (size_i == SZ_B && step_i != 2'd0) illegal_o = 1'b1;
      end
      OP_ADDA, OP_SUBA: begin
        if (size_i != SZ_L || step_i == 2'd3) illegal_o = 1'b1;
      end
      OP_DADJA, OP_DADJS: if (size_i != SZ_B) illegal_o = 1'b1;
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
  import addsub_pkg::*;
#(
  parameter int unsigned W_DATA = DW
) (
  input  logic [W_DATA-1:0] a_i,
  input  logic [W_DATA-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  input  logic [1:0]        size_i,
  output logic [W_DATA-1:0] res_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              h_o
);
  logic [W_DATA-1:0] lane_res [NLANE];
  logic [NLANE-1:0]  lane_n, lane_z, lane_v, lane_c, lane_h;

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    localparam int unsigned W  = 8 << gi;
    localparam int unsigned HB = W - 4;   // half-carry taken out of bit W-5
    logic [W:0]  full;
    logic [HB:0] half;
    logic        a_msb, b_msb, r_msb;

    assign full = sub_i
      ? ({1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]} - (W+1)'(cin_i))
      : ({1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]} + (W+1)'(cin_i));
    assign half = sub_i
      ? ({1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - (HB+1)'(cin_i))
      : ({1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + (HB+1)'(cin_i));

    assign a_msb = a_i[W-1];
    assign b_msb = b_i[W-1];
    assign r_msb = full[W-1];

    assign lane_n[gi] = r_msb;
    assign lane_z[gi] = (full[W-1:0] == '0);
    assign lane_c[gi] = full[W];
    assign lane_h[gi] = half[HB];
    assign lane_v[gi] = (sub_i ? (a_msb != b_msb) : (a_msb == b_msb)) && (r_msb != a_msb);

    if (W < W_DATA) begin : g_part
      assign lane_res[gi] = {a_i[W_DATA-1:W], full[W-1:0]};
    end else begin : g_full
      assign lane_res[gi] = full[W_DATA-1:0];
    end
  end

  logic [1:0] sel;
  assign sel = (size_i == SZ_X) ? 2'(SZ_L) : size_i;

  assign res_o = lane_res[sel];
  assign n_o   = lane_n[sel];
  assign z_o   = lane_z[sel];
  assign v_o   = lane_v[sel];
  assign c_o   = lane_c[sel];
  assign h_o   = lane_h[sel];
endmodule

// File: rtl/addsub_dadj.sv
module addsub_dadj
  import addsub_pkg::*;
(
  input  logic [BCD_W-1:0] val_i,
  input  logic             sub_i,
  input  logic             c_i,
  input  logic             h_i,
  output logic [BCD_W-1:0] val_o,
  output logic             c_o
);
  logic       lo_fix, hi_fix;
  logic [7:0] corr;

  always_comb begin
    if (sub_i) begin
      lo_fix = h_i;
      hi_fix = c_i;
    end else begin
      lo_fix = h_i || (val_i[3:0] > 4'd9);
      hi_fix = c_i || (val_i > 8'h99);
    end
    corr  = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    val_o = sub_i ? (val_i - corr) : (val_i + corr);
    c_o   = hi_fix;
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [3:0]  op_i,
  input  logic [1:0]  size_i,
  input  logic        imm_i,
  input  logic [1:0]  step_i,
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  input  logic [4:0]  flags_i,
  output logic        valid_o,
  output logic        illegal_o,
  output logic [31:0] res_o,
  output logic [4:0]  flags_o
);
  flags_t      fin, fnext;
  logic        illegal;
  logic [DW-1:0] b_opnd, step_val, add_res, rnext;
  logic        cin, is_sub;
  logic        a_n, a_z, a_v, a_c, a_h;
  logic [BCD_W-1:0] dj_val;
  logic        dj_c;

  assign fin      = flags_t'(flags_i);
  assign step_val = DW'(1) << step_i;

  addsub_legal u_legal (
    .op_i      (op_i),
    .size_i    (size_i),
    .imm_i     (imm_i),
    .step_i    (step_i),
    .illegal_o (illegal)
  );

  always_comb begin
    b_opnd = src_i;
    cin    = 1'b0;
    is_sub = 1'b0;
    unique case (op_i)
      OP_SUB:            is_sub = 1'b1;
      OP_ADDC:           cin = fin.c;
      OP_SUBC:           begin cin = fin.c; is_sub = 1'b1; end
      OP_INC, OP_ADDA:   b_opnd = step_val;
      OP_DEC, OP_SUBA:   begin b_opnd = step_val; is_sub = 1'b1; end
      default: ;
    endcase
  end

  addsub_adder #(.W_DATA(DW)) u_adder (
    .a_i    (dst_i),
    .b_i    (b_opnd),
    .cin_i  (cin),
    .sub_i  (is_sub),
    .size_i (size_i),
    .res_o  (add_res),
    .n_o    (a_n),
    .z_o    (a_z),
    .v_o    (a_v),
    .c_o    (a_c),
    .h_o    (a_h)
  );

  addsub_dadj u_dadj (
    .val_i (dst_i[BCD_W-1:0]),
    .sub_i (op_i == OP_DADJS),
    .c_i   (fin.c),
    .h_i   (fin.h),
    .val_o (dj_val),
    .c_o   (dj_c)
  );

  always_comb begin
    rnext = dst_i;
    fnext = fin;
    if (!illegal) begin
      unique case (op_i)
        OP_ADD, OP_SUB: begin
          rnext = add_res;
          fnext = '{n: a_n, z: a_z, v: a_v, c: a_c, h: a_h};
        end
        OP_ADDC, OP_SUBC: begin
          rnext = add_res;
          fnext = '{n: a_n, z: a_z & fin.z, v: a_v, c: a_c, h: a_h};
        end
        OP_INC, OP_DEC: begin
          rnext   = add_res;
          fnext.n = a_n;
          fnext.z = a_z;
          fnext.v = a_v;
        end
        OP_ADDA, OP_SUBA: rnext = add_res;
        OP_DADJA, OP_DADJS: begin
          rnext   = {dst_i[DW-1:BCD_W], dj_val};
          fnext.n = dj_val[BCD_W-1];
          fnext.z = (dj_val == '0);
          fnext.c = dj_c;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      res_o     <= '0;
      flags_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= illegal;
        res_o     <= rnext;
        flags_o   <= fnext;
      end
    end
  end

  a_r10_illegal_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && illegal |=> illegal_o && res_o == $past(dst_i) && flags_o == $past(flags_i));

  a_r5_addr_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !illegal && (op_i == OP_ADDA || op_i == OP_SUBA) |=> flags_o == $past(flags_i));

  a_r3_carry_half_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !illegal && (op_i == OP_INC || op_i == OP_DEC)
    |=> flags_o[1:0] == $past(flags_i[1:0]));

  a_r2_zero_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !illegal && (op_i == OP_ADDC || op_i == OP_SUBC) && !flags_i[3] |=> !flags_o[3]);

  a_r1_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !illegal && size_i == SZ_B && op_i <= OP_DEC |=> res_o[31:8] == $past(dst_i[31:8]));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(flags_o) && $stable(illegal_o));
endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;
  typedef struct packed {
    logic [7:0]  tag;
    logic [3:0]  op;
    logic [1:0]  size;
    logic        imm;
    logic [1:0]  step;
    logic [31:0] dst;
    logic [31:0] src;
    logic [4:0]  fin;
    logic [31:0] eres;
    logic [4:0]  efl;
    logic        eill;
  } vec_t;

  localparam int NV = 26;
  // flags {N,Z,V,C,H}
  localparam vec_t VECS [NV] = '{
    '{8'd1,  4'd0, 2'd0, 1'b0, 2'd0, 32'h1234_5678, 32'h0000_0088, 5'b00000, 32'h1234_5600, 5'b01011, 1'b0}, // R1
    '{8'd1,  4'd0, 2'd1, 1'b0, 2'd0, 32'h0000_7FFF, 32'h0000_0001, 5'b00000, 32'h0000_8000, 5'b10101, 1'b0}, // R1
    '{8'd1,  4'd1, 2'd2, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0001, 5'b00000, 32'hFFFF_FFFF, 5'b10011, 1'b0}, // R1
    '{8'd1,  4'd0, 2'd0, 1'b0, 2'd0, 32'hFFFF_FF80, 32'h0000_0080, 5'b00000, 32'hFFFF_FF00, 5'b01110, 1'b0}, // R1
    '{8'd2,  4'd2, 2'd2, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 5'b01010, 32'h0000_0000, 5'b01011, 1'b0}, // R2
    '{8'd2,  4'd2, 2'd0, 1'b0, 2'd0, 32'h0000_0010, 32'h0000_0020, 5'b01000, 32'h0000_0030, 5'b00000, 1'b0}, // R2
    '{8'd2,  4'd3, 2'd1, 1'b0, 2'd0, 32'h0000_0005, 32'h0000_0005, 5'b00010, 32'h0000_FFFF, 5'b10011, 1'b0}, // R2
    '{8'd2,  4'd3, 2'd0, 1'b0, 2'd0, 32'h0000_0005, 32'h0000_0005, 5'b00000, 32'h0000_0000, 5'b00000, 1'b0}, // R2
    '{8'd3,  4'd4, 2'd0, 1'b0, 2'd0, 32'h0000_007F, 32'h0000_0000, 5'b00010, 32'h0000_0080, 5'b10110, 1'b0}, // R3
    '{8'd3,  4'd5, 2'd1, 1'b0, 2'd1, 32'h0000_0001, 32'h0000_0000, 5'b00001, 32'h0000_FFFF, 5'b10001, 1'b0}, // R3
    '{8'd4,  4'd4, 2'd0, 1'b0, 2'd1, 32'h0000_00AB, 32'h0000_0000, 5'b10101, 32'h0000_00AB, 5'b10101, 1'b1}, // R4
    '{8'd4,  4'd5, 2'd2, 1'b0, 2'd2, 32'h0000_0040, 32'h0000_0000, 5'b00110, 32'h0000_0040, 5'b00110, 1'b1}, // R4
    '{8'd5,  4'd6, 2'd2, 1'b0, 2'd2, 32'hFFFF_FFFE, 32'h0000_0000, 5'b01010, 32'h0000_0002, 5'b01010, 1'b0}, // R5
    '{8'd5,  4'd7, 2'd2, 1'b0, 2'd1, 32'h0000_0001, 32'h0000_0000, 5'b00000, 32'hFFFF_FFFF, 5'b00000, 1'b0}, // R5
    '{8'd6,  4'd6, 2'd1, 1'b0, 2'd0, 32'h0000_1234, 32'h0000_0000, 5'b00100, 32'h0000_1234, 5'b00100, 1'b1}, // R6
    '{8'd6,  4'd7, 2'd2, 1'b0, 2'd3, 32'h0000_0005, 32'h0000_0000, 5'b10000, 32'h0000_0005, 5'b10000, 1'b1}, // R6
    '{8'd7,  4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_003C, 32'h0000_0000, 5'b00000, 32'h0000_0042, 5'b00000, 1'b0}, // R7
    '{8'd7,  4'd8, 2'd0, 1'b0, 2'd0, 32'h0000_0032, 32'h0000_0000, 5'b00011, 32'h0000_0098, 5'b10011, 1'b0}, // R7
    '{8'd7,  4'd8, 2'd0, 1'b0, 2'd0, 32'hAB00_009A, 32'h0000_0000, 5'b00000, 32'hAB00_0000, 5'b01010, 1'b0}, // R7
    '{8'd7,  4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_002D, 32'h0000_0000, 5'b00001, 32'h0000_0027, 5'b00001, 1'b0}, // R7
    '{8'd7,  4'd9, 2'd0, 1'b0, 2'd0, 32'h0000_00EE, 32'h0000_0000, 5'b00011, 32'h0000_0088, 5'b10011, 1'b0}, // R7
    '{8'd8,  4'd8, 2'd1, 1'b0, 2'd0, 32'h0000_1234, 32'h0000_0000, 5'b11111, 32'h0000_1234, 5'b11111, 1'b1}, // R8
    '{8'd9,  4'd1, 2'd0, 1'b1, 2'd0, 32'h0000_0010, 32'h0000_0001, 5'b00000, 32'h0000_0010, 5'b00000, 1'b1}, // R9
    '{8'd9,  4'd1, 2'd1, 1'b1, 2'd0, 32'h0000_0100, 32'h0000_0001, 5'b00000, 32'h0000_00FF, 5'b00000, 1'b0}, // R9
    '{8'd10, 4'd0, 2'd3, 1'b0, 2'd0, 32'h0000_CAFE, 32'h0000_0001, 5'b01000, 32'h0000_CAFE, 5'b01000, 1'b1}, // R10
    '{8'd10, 4'd15,2'd2, 1'b0, 2'd0, 32'h0BAD_F00D, 32'h0000_0001, 5'b00101, 32'h0BAD_F00D, 5'b00101, 1'b1}  // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic        imm_i = 1'b0;
  logic [1:0]  step_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [4:0]  flags_i = '0;
  logic        valid_o, illegal_o;
  logic [31:0] res_o;
  logic [4:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  addsub_unit u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .size_i    (size_i),
    .imm_i     (imm_i),
    .step_i    (step_i),
    .dst_i     (dst_i),
    .src_i     (src_i),
    .flags_i   (flags_i),
    .valid_o   (valid_o),
    .illegal_o (illegal_o),
    .res_o     (res_o),
    .flags_o   (flags_o)
  );

  task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v/ill/res/fl=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    valid_i = 1'b1;
    op_i = v.op; size_i = v.size; imm_i = v.imm; step_i = v.step;
    dst_i = v.dst; src_i = v.src; flags_i = v.fin;
    @(negedge clk_i);
    valid_i = 1'b0;
    check($sformatf("R%0d vector op=%0d", v.tag, v.op),
          {valid_o, illegal_o, res_o, flags_o}, {1'b1, v.eill, v.eres, v.efl});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11 reset", {valid_o, illegal_o, res_o, flags_o}, 39'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R11: hold while valid_i low, after a known result
    apply(VECS[0]);
    dst_i = 32'hDEAD_BEEF; src_i = 32'h1; op_i = 4'd1; flags_i = 5'b11111;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R11 hold", {valid_o, illegal_o, res_o, flags_o},
          {1'b0, 1'b0, 32'h1234_5600, 5'b01011});

    // R1: back-to-back requests with no idle cycle
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 4'd0; size_i = 2'd2; imm_i = 1'b0; step_i = 2'd0;
    dst_i = 32'h7FFF_FFFF; src_i = 32'h1; flags_i = 5'b00000;
    @(negedge clk_i);
    check("R1 long overflow", {valid_o, illegal_o, res_o, flags_o},
          {1'b1, 1'b0, 32'h8000_0000, 5'b10101});
    op_i = 4'd4; size_i = 2'd1; step_i = 2'd1; dst_i = 32'h5555_FFFE; flags_i = 5'b00011;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R3 word wrap", {valid_o, illegal_o, res_o, flags_o},
          {1'b1, 1'b0, 32'h5555_0000, 5'b01011});

    // R11: reset mid-stream clears outputs
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R11 re-reset", {valid_o, illegal_o, res_o, flags_o}, 39'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule